// File: doc/BRIEF.md
# Dual-Channel Wiper and Stored-Setting Register Executor

This block carries out already-decoded commands for two digitally controlled potentiometer channels. Each channel owns one volatile wiper register, whose value drives the tap selection of its resistor array, and four stored-setting registers that stand in for nonvolatile memory. A serial bus front end delivers one command at a time as an opcode, a register index, a channel index and a data byte, with a single-cycle strobe once the bus transaction has closed. The block then updates its registers, presents read results, and models the long store time of nonvolatile memory with a busy flag that lasts a fixed number of clock cycles.

Stores can be blocked by an active-low write-protect input, and this affects stored-setting targets only. Transfers move values between a channel's wiper and one of its stored settings, either for the addressed channel or for both channels at once. After reset each wiper is reloaded from stored setting 0 of its channel. An up/down stepping mode lets the front end move the selected wiper one tap per step pulse. Each step saturates at the ends of the range.

Top module: `pot_reg_exec`

## Requirements
- R1: While rst_n is low, wiper0, wiper1 and rd_data are 0 and busy is 0. Within 3 clock edges after rst_n rises, each wiper holds stored setting 0 of its channel, and no command strobe is taken before that load.
- R2: A taken command with opcode 4'b1001 loads rd_data with the wiper of channel cmd_pot. Opcode 4'b1011 loads rd_data with stored setting cmd_reg of channel cmd_pot. Both take effect on the clock edge that samples the strobe. rd_data holds its value through all other commands.
- R3: Opcode 4'b1010 writes cmd_wdata into the wiper of channel cmd_pot on the strobe edge, and busy is not asserted.
- R4: Opcode 4'b1101 copies stored setting cmd_reg of channel cmd_pot into that channel's wiper. Opcode 4'b0001 does the same for both channels at once and ignores cmd_pot. Both take effect on the strobe edge and do not assert busy.
- R5: With wp_n high, three opcodes write a stored setting. 4'b1100 writes cmd_wdata into setting cmd_reg of channel cmd_pot. 4'b1110 stores that channel's wiper there. 4'b1000 stores each channel's wiper into setting cmd_reg of the same channel. Each of these raises busy on the strobe edge for exactly NV_CYCLES cycles.
- R6: With wp_n low, the three storing opcodes leave every stored setting unchanged and do not raise busy.
- R7: While busy is high, command strobes and step pulses are ignored, and both wipers hold their values.
- R8: Opcode 4'b0010 selects channel cmd_pot for stepping. Until the next taken command, each step_valid pulse moves that wiper up by 1 (step_up=1) or down by 1 (step_up=0). A step stops at 255 going up and at 0 going down. Step pulses have no effect when the most recent taken command was not 4'b0010.
- R9: Any opcode outside the nine listed above (for example 4'b0111) changes no wiper, no stored setting, no rd_data and no busy.
- R10: cmd_reg values 0 to 3 select stored settings 0 to 3. cmd_pot 0 selects channel 0, whose wiper appears on wiper0, and cmd_pot 1 selects channel 1, whose wiper appears on wiper1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is complete |
| cmd_op | input | 4 | Command opcode |
| cmd_reg | input | 2 | Stored-setting index |
| cmd_pot | input | 1 | Channel index |
| cmd_wdata | input | 8 | Data byte for write commands |
| step_valid | input | 1 | One-cycle step pulse in stepping mode |
| step_up | input | 1 | Step direction, 1 = up |
| wp_n | input | 1 | Active-low write protect for stored settings |
| rd_data | output | 8 | Last read result |
| busy | output | 1 | Store in progress |
| wiper0 | output | 8 | Channel 0 wiper value |
| wiper1 | output | 8 | Channel 1 wiper value |

## Verification
The wipers are visible on the ports at all times, so a bad wiper update shows up on the first sample after the strobe edge. A corrupted stored setting stays hidden until a later read or transfer brings it out, and the test sequence therefore reads back or transfers every setting it writes. A busy timer that runs long or short shows up as a wrong busy pulse length, and also as commands being taken or dropped at the wrong time. A stepping mode that stays latched shows up as a wiper that moves on a step pulse that follows some other command.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [3:0] {
    OP_GDR2W    = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_GW2DR    = 4'b1000,
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DR    = 4'b1011,
    OP_WR_DR    = 4'b1100,
    OP_DR2W     = 4'b1101,
    OP_W2DR     = 4'b1110
  } pot_op_e;
endpackage

// File: rtl/pot_channel.sv
module pot_channel #(
  parameter int W = 8,
  parameter int NREG = 4,
  parameter int IDX_W = 2,
  parameter logic [NREG*W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wiper_we,
  input  logic [W-1:0]      wiper_d,
  input  logic              dr_we,
  input  logic [IDX_W-1:0]  dr_idx,
  input  logic [W-1:0]      dr_d,
  output logic [W-1:0]      wiper_q,
  output logic [NREG*W-1:0] dr_q
);
  logic [W-1:0]      wiper_n;
  logic [NREG*W-1:0] dr_n;

  always_comb begin
    wiper_n = wiper_q;
    dr_n    = dr_q;
    if (wiper_we) wiper_n = wiper_d;
    if (dr_we) dr_n[int'(dr_idx)*W +: W] = dr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= '0;
      dr_q    <= INIT;
    end else begin
      if (wiper_we) wiper_q <= wiper_n;
      if (dr_we)    dr_q    <= dr_n;
    end
  end
endmodule

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int NV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)            cnt_n = CNT_W'(NV_CYCLES);
    else if (cnt_q != '0) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pot_cmd_ctrl.sv
module pot_cmd_ctrl
  import pot_pkg::*;
#(
  parameter int W = 8,
  parameter int NPOT = 2,
  parameter int NREG = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int POT_W = $clog2(NPOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [3:0]             cmd_op,
  input  logic [IDX_W-1:0]       cmd_reg,
  input  logic [POT_W-1:0]       cmd_pot,
  input  logic [W-1:0]           cmd_wdata,
  input  logic                   step_valid,
  input  logic                   step_up,
  input  logic                   wp_n,
  input  logic                   busy,
  input  logic [NPOT*W-1:0]      wiper_all,
  input  logic [NPOT*NREG*W-1:0] dr_all,
  output logic [NPOT-1:0]        wiper_we,
  output logic [NPOT*W-1:0]      wiper_d,
  output logic [NPOT-1:0]        dr_we,
  output logic [IDX_W-1:0]       dr_idx,
  output logic [NPOT*W-1:0]      dr_d,
  output logic                   nv_start,
  output logic [W-1:0]           rd_data
);
  logic             recall_q;
  logic             step_mode_q, step_mode_n;
  logic [POT_W-1:0] step_pot_q, step_pot_n;
  logic [W-1:0]     rd_q, rd_n;
  logic             accept;
  logic [W-1:0]     cur;

  assign accept = cmd_valid && !busy && !recall_q;

  always_comb begin
    wiper_we    = '0;
    wiper_d     = '0;
    dr_we       = '0;
    dr_d        = '0;
    dr_idx      = cmd_reg;
    rd_n        = rd_q;
    step_mode_n = step_mode_q;
    step_pot_n  = step_pot_q;
    cur         = wiper_all[int'(step_pot_q)*W +: W];
    if (recall_q) begin
      for (int p = 0; p < NPOT; p++) begin
        wiper_we[p]         = 1'b1;
        wiper_d[p*W +: W]   = dr_all[(p*NREG)*W +: W];
      end
    end else if (accept) begin
      step_mode_n = 1'b0;
      case (cmd_op)
        OP_RD_WIPER: rd_n = wiper_all[int'(cmd_pot)*W +: W];
        OP_RD_DR:    rd_n = dr_all[(int'(cmd_pot)*NREG + int'(cmd_reg))*W +: W];
        OP_STEP: begin
          step_mode_n = 1'b1;
          step_pot_n  = cmd_pot;
        end
        default: ;
      endcase
      for (int p = 0; p < NPOT; p++) begin
        case (cmd_op)
          OP_WR_WIPER: if (p == int'(cmd_pot)) begin
            wiper_we[p] = 1'b1;
            wiper_d[p*W +: W] = cmd_wdata;
          end
          OP_DR2W: if (p == int'(cmd_pot)) begin
            wiper_we[p] = 1'b1;
            wiper_d[p*W +: W] = dr_all[(p*NREG + int'(cmd_reg))*W +: W];
          end
          OP_GDR2W: begin
            wiper_we[p] = 1'b1;
            wiper_d[p*W +: W] = dr_all[(p*NREG + int'(cmd_reg))*W +: W];
          end
          OP_WR_DR: if (p == int'(cmd_pot) && wp_n) begin
            dr_we[p] = 1'b1;
            dr_d[p*W +: W] = cmd_wdata;
          end
          OP_W2DR: if (p == int'(cmd_pot) && wp_n) begin
            dr_we[p] = 1'b1;
            dr_d[p*W +: W] = wiper_all[p*W +: W];
          end
          OP_GW2DR: if (wp_n) begin
            dr_we[p] = 1'b1;
            dr_d[p*W +: W] = wiper_all[p*W +: W];
          end
          default: ;
        endcase
      end
    end else if (step_mode_q && step_valid && !busy) begin
      for (int p = 0; p < NPOT; p++) begin
        if (p == int'(step_pot_q)) begin
          wiper_we[p] = 1'b1;
          if (step_up) wiper_d[p*W +: W] = (cur == '1) ? cur : cur + W'(1);
          else         wiper_d[p*W +: W] = (cur == '0) ? cur : cur - W'(1);
        end
      end
    end
  end

  assign nv_start = |dr_we;
  assign rd_data  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recall_q    <= 1'b1;
      step_mode_q <= 1'b0;
      step_pot_q  <= '0;
      rd_q        <= '0;
    end else begin
      recall_q    <= 1'b0;
      step_mode_q <= step_mode_n;
      step_pot_q  <= step_pot_n;
      if (accept) rd_q <= rd_n;
    end
  end
endmodule

// File: rtl/pot_reg_exec.sv
module pot_reg_exec #(
  parameter int W = 8,
  parameter int NREG = 4,
  parameter int NV_CYCLES = 40,
  parameter logic [2*NREG*W-1:0] DR_INIT = 64'h7766_55C3_3322_1140,
  localparam int NPOT = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_reg,
  input  logic             cmd_pot,
  input  logic [W-1:0]     cmd_wdata,
  input  logic             step_valid,
  input  logic             step_up,
  input  logic             wp_n,
  output logic [W-1:0]     rd_data,
  output logic             busy,
  output logic [W-1:0]     wiper0,
  output logic [W-1:0]     wiper1
);
  logic                   rst_s1, rst_sync_n;
  logic [NPOT-1:0]        wiper_we, dr_we;
  logic [NPOT*W-1:0]      wiper_d, dr_d, wiper_all;
  logic [NPOT*NREG*W-1:0] dr_all;
  logic [IDX_W-1:0]       dr_idx;
  logic                   nv_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  pot_cmd_ctrl #(.W(W), .NPOT(NPOT), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata),
    .step_valid(step_valid), .step_up(step_up), .wp_n(wp_n), .busy(busy),
    .wiper_all(wiper_all), .dr_all(dr_all), .wiper_we(wiper_we),
    .wiper_d(wiper_d), .dr_we(dr_we), .dr_idx(dr_idx), .dr_d(dr_d),
    .nv_start(nv_start), .rd_data(rd_data)
  );

  generate
    for (genvar p = 0; p < NPOT; p++) begin : g_ch
      pot_channel #(
        .W(W), .NREG(NREG), .IDX_W(IDX_W),
        .INIT(DR_INIT[p*NREG*W +: NREG*W])
      ) u_ch (
        .clk(clk), .rst_n(rst_sync_n),
        .wiper_we(wiper_we[p]), .wiper_d(wiper_d[p*W +: W]),
        .dr_we(dr_we[p]), .dr_idx(dr_idx), .dr_d(dr_d[p*W +: W]),
        .wiper_q(wiper_all[p*W +: W]), .dr_q(dr_all[p*NREG*W +: NREG*W])
      );
    end
  endgenerate

  pot_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(nv_start), .busy(busy)
  );

  assign wiper0 = wiper_all[0 +: W];
  assign wiper1 = wiper_all[W +: W];
endmodule

// File: rtl/pot_reg_exec_chk.sv
module pot_reg_exec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [3:0]   cmd_op,
  input logic         cmd_pot,
  input logic [W-1:0] cmd_wdata,
  input logic         wp_n,
  input logic         busy,
  input logic [W-1:0] wiper0,
  input logic [W-1:0] wiper1
);
  logic [1:0] up_cnt;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               up_cnt <= '0;
    else if (up_cnt != 2'd3)  up_cnt <= up_cnt + 2'd1;
  end
  assign ready = (up_cnt == 2'd3);

  AST_WIPER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ready && cmd_valid && !busy && cmd_op == 4'b1010 && !cmd_pot
      |=> wiper0 == $past(cmd_wdata)); // R3
  AST_STORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && cmd_valid && !busy && wp_n && cmd_op == 4'b1100 |=> busy); // R5
  AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && cmd_valid && !busy && !wp_n &&
    (cmd_op == 4'b1100 || cmd_op == 4'b1110 || cmd_op == 4'b1000) |=> !busy); // R6
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wiper0) && $stable(wiper1)); // R7
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    ready && cmd_valid && !busy && cmd_op == 4'b0111
      |=> $stable(wiper0) && $stable(wiper1) && !busy); // R9
endmodule

bind pot_reg_exec pot_reg_exec_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata), .wp_n(wp_n), .busy(busy),
  .wiper0(wiper0), .wiper1(wiper1)
);

// File: tb/tb_pot_reg_exec.sv
module tb_pot_reg_exec;
  localparam int NV = 20;
  logic clk = 1'b0;
  logic rst_n, cmd_valid, cmd_pot, step_valid, step_up, wp_n, busy;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [7:0] cmd_wdata, rd_data, wiper0, wiper1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pot_reg_exec #(.NV_CYCLES(NV)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_wdata(cmd_wdata),
    .step_valid(step_valid), .step_up(step_up), .wp_n(wp_n),
    .rd_data(rd_data), .busy(busy), .wiper0(wiper0), .wiper1(wiper1)
  );

  // op, reg, pot, wdata, wp_n | exp wiper0, wiper1, rd_data, busy
  localparam logic [40:0] VEC [20] = '{
    {4'h9, 2'd0, 1'b0, 8'h00, 1'b1, 8'h40, 8'hC3, 8'h40, 1'b0}, // R2 R10
    {4'h9, 2'd0, 1'b1, 8'h00, 1'b1, 8'h40, 8'hC3, 8'hC3, 1'b0}, // R2
    {4'hA, 2'd0, 1'b0, 8'h5A, 1'b1, 8'h5A, 8'hC3, 8'hC3, 1'b0}, // R3
    {4'hB, 2'd2, 1'b1, 8'h00, 1'b1, 8'h5A, 8'hC3, 8'h66, 1'b0}, // R2
    {4'hC, 2'd1, 1'b0, 8'h9E, 1'b1, 8'h5A, 8'hC3, 8'h66, 1'b1}, // R5
    {4'hB, 2'd1, 1'b0, 8'h00, 1'b1, 8'h5A, 8'hC3, 8'h9E, 1'b0}, // R5
    {4'hD, 2'd1, 1'b1, 8'h00, 1'b1, 8'h5A, 8'h55, 8'h9E, 1'b0}, // R4
    {4'hE, 2'd3, 1'b1, 8'h00, 1'b1, 8'h5A, 8'h55, 8'h9E, 1'b1}, // R5
    {4'hB, 2'd3, 1'b1, 8'h00, 1'b1, 8'h5A, 8'h55, 8'h55, 1'b0}, // R5
    {4'h1, 2'd2, 1'b1, 8'h00, 1'b1, 8'h22, 8'h66, 8'h55, 1'b0}, // R4
    {4'hA, 2'd0, 1'b1, 8'h0F, 1'b1, 8'h22, 8'h0F, 8'h55, 1'b0}, // R3
    {4'h8, 2'd0, 1'b0, 8'h00, 1'b1, 8'h22, 8'h0F, 8'h55, 1'b1}, // R5
    {4'hB, 2'd0, 1'b1, 8'h00, 1'b1, 8'h22, 8'h0F, 8'h0F, 1'b0}, // R5
    {4'hB, 2'd0, 1'b0, 8'h00, 1'b1, 8'h22, 8'h0F, 8'h22, 1'b0}, // R5
    {4'hC, 2'd3, 1'b0, 8'hAA, 1'b0, 8'h22, 8'h0F, 8'h22, 1'b0}, // R6
    {4'hB, 2'd3, 1'b0, 8'h00, 1'b1, 8'h22, 8'h0F, 8'h33, 1'b0}, // R6
    {4'h7, 2'd1, 1'b0, 8'hFF, 1'b1, 8'h22, 8'h0F, 8'h33, 1'b0}, // R9
    {4'h8, 2'd1, 1'b0, 8'h00, 1'b0, 8'h22, 8'h0F, 8'h33, 1'b0}, // R6
    {4'hB, 2'd1, 1'b1, 8'h00, 1'b1, 8'h22, 8'h0F, 8'h55, 1'b0}, // R6
    {4'hD, 2'd3, 1'b1, 8'h00, 1'b1, 8'h22, 8'h55, 8'h55, 1'b0}  // R4
  };

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] rg, logic pt, logic [7:0] wd, logic wp);
    @(negedge clk);
    cmd_op = op; cmd_reg = rg; cmd_pot = pt; cmd_wdata = wd; wp_n = wp;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic step(logic up);
    @(negedge clk);
    step_valid = 1'b1; step_up = up;
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4*NV && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_reg = '0; cmd_pot = 1'b0;
    cmd_wdata = '0; step_valid = 1'b0; step_up = 1'b0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wiper0 in reset", wiper0, 8'h00);
    check("R1 wiper1 in reset", wiper1, 8'h00);
    check("R1 rd_data in reset", rd_data, 8'h00);
    check("R1 busy in reset", {7'b0, busy}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 recall wiper0", wiper0, 8'h40);
    check("R1 recall wiper1", wiper1, 8'h C3);

    foreach (VEC[i]) begin
      issue(VEC[i][40:37], VEC[i][36:35], VEC[i][34], VEC[i][33:26], VEC[i][25]);
      check($sformatf("vec%0d wiper0 R3 R4", i), wiper0, VEC[i][24:17]);
      check($sformatf("vec%0d wiper1 R4 R10", i), wiper1, VEC[i][16:9]);
      check($sformatf("vec%0d rd_data R2", i), rd_data, VEC[i][8:1]);
      check($sformatf("vec%0d busy R5 R6", i), {7'b0, busy}, {7'b0, VEC[i][0]});
      wait_idle();
    end

    // R5 busy length and R7 commands dropped while busy
    issue(4'hC, 2'd2, 1'b0, 8'h77, 1'b1);
    cnt = 0;
    for (int i = 0; i < 4*NV && busy; i++) begin
      if (i == 1) begin
        cmd_op = 4'hA; cmd_pot = 1'b0; cmd_wdata = 8'h01; cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      if (i == 3) step_valid = 1'b1; else step_valid = 1'b0;
      cnt++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; step_valid = 1'b0;
    check("R5 busy cycles", 8'(cnt), 8'(NV));
    check("R7 wiper0 held during busy", wiper0, 8'h22);
    issue(4'hB, 2'd2, 1'b0, 8'h00, 1'b1);
    check("R5 stored value read back", rd_data, 8'h77);

    // R8 stepping
    issue(4'h2, 2'd0, 1'b0, 8'h00, 1'b1);
    step(1'b1); step(1'b1); step(1'b1);
    check("R8 step up", wiper0, 8'h25);
    step(1'b0);
    check("R8 step down", wiper0, 8'h24);
    check("R8 other channel unchanged", wiper1, 8'h55);
    issue(4'hA, 2'd0, 1'b1, 8'hFE, 1'b1);
    step(1'b1);
    check("R8 step ignored after other command", wiper1, 8'hFE);
    issue(4'h2, 2'd0, 1'b1, 8'h00, 1'b1);
    step(1'b1); step(1'b1); step(1'b1);
    check("R8 saturate high", wiper1, 8'hFF);
    issue(4'hA, 2'd0, 1'b1, 8'h01, 1'b1);
    issue(4'h2, 2'd0, 1'b1, 8'h00, 1'b1);
    step(1'b0); step(1'b0); step(1'b0);
    check("R8 saturate low", wiper1, 8'h00);
    check("R8 wiper0 untouched", wiper0, 8'h24);

    summary();
  end
endmodule